// File: doc/BRIEF.md
# External Bus Write-Cycle Controller

This block turns single write requests from an on-chip host into write cycles on an external asynchronous memory bus. Each cycle has three timed phases measured in interface clock periods. In the setup phase, chip-select, address and the direction line assert. In the strobe phase, the active-low write strobe is low and the data driver is enabled. In the hold phase, the strobe is released while chip-select, direction and data stay put.

The host raises a request with an address and a data word and holds it until a one-cycle acknowledge arrives at the end of the hold phase. An external ready input can stretch the strobe phase. The ready decision is taken on the last programmed strobe cycle and repeated on every following cycle until ready is seen high.

In synchronous ready mode the decision uses ready as it stands at that edge. In asynchronous mode ready passes through a two-flop synchronizer first, so each decision reflects ready as it stood two cycles earlier.

Top module: `ext_write_ctrl`

## Requirements
- R1: While reset is held and after its release with no request, bus_cs_n, bus_we_n and bus_rnw are 1, bus_data_oe and req_ack are 0, and bus_addr is 0.
- R2: A request seen in the idle state starts the cycle at the next clock edge: bus_cs_n is 0 and bus_we_n is 1 for max(cfg_lead,1) cycles.
- R3: With ready ignored, bus_we_n is 0 for exactly max(cfg_active,1) consecutive cycles directly after the setup phase.
- R4: After bus_we_n rises, bus_cs_n stays 0 for max(cfg_trail,1) cycles, then returns to 1.
- R5: bus_rnw equals bus_cs_n on every cycle. bus_data_oe is 1 exactly during the strobe and hold phases.
- R6: req_ack is 1 for exactly one cycle, the last hold-phase cycle. A request is accepted only while idle.
- R7: cfg_rdy_mode = 1 (synchronous): the strobe phase ends on the first cycle, no earlier than the last programmed strobe cycle, in which ext_ready is 1.
- R8: cfg_rdy_mode = 2 (asynchronous): the strobe phase ends on the first cycle k, no earlier than the last programmed strobe cycle, for which ext_ready was 1 in cycle k-2.
- R9: bus_addr and bus_data keep the values captured at acceptance for the whole cycle. bus_addr keeps the last address while idle, whatever req_addr does.
- R10: A phase count of 0 behaves as a count of 1.
- R11: The counts and the ready mode are captured at acceptance. Changing them during a cycle has no effect on that cycle.
- R12: cfg_rdy_mode values 0 and 3 both ignore ext_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Host write request, held until acknowledged |
| req_addr | input | AW | Write address |
| req_data | input | DW | Write data |
| req_ack | output | 1 | One-cycle completion pulse |
| cfg_lead | input | CW | Setup-phase length in clocks |
| cfg_active | input | CW | Minimum strobe-phase length in clocks |
| cfg_trail | input | CW | Hold-phase length in clocks |
| cfg_rdy_mode | input | 2 | 0/3 ignore, 1 synchronous, 2 asynchronous |
| ext_ready | input | 1 | External ready |
| bus_cs_n | output | 1 | Chip-select, active low |
| bus_addr | output | AW | External address |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_rnw | output | 1 | Direction line, low during a write |
| bus_data | output | DW | Write data toward the pad |
| bus_data_oe | output | 1 | Enable for the pad tri-state data driver |

## Verification
A phase counter that loads or decrements wrongly shows up in the very access where it happens, as a strobe edge or chip-select edge displaced by whole cycles. A ready decision taken from the wrong source or at the wrong cycle moves the strobe rise by exactly the synchronizer delay or by the wait length. The bench therefore sweeps ready rise times across the decision point in both modes. Configuration captured late, or an address register that follows the host while idle, shows up at the ports within one cycle of the disturbing input change.

// File: rtl/ewc_pkg.sv
package ewc_pkg;
  typedef enum logic [1:0] {
    RDY_OFF   = 2'd0,
    RDY_SYNC  = 2'd1,
    RDY_ASYNC = 2'd2,
    RDY_OFF2  = 2'd3
  } rdy_mode_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_LEAD   = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_TRAIL  = 2'd3
  } phase_e;
endpackage

// File: rtl/ewc_rdy_sync.sv
module ewc_rdy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sh <= '0;
        else        sh <= d;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], d};
    end
  endgenerate

  assign q = sh[STAGES-1];
endmodule

// File: rtl/ewc_phase_fsm.sv
module ewc_phase_fsm
  import ewc_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] lead,
  input  logic [CW-1:0] active,
  input  logic [CW-1:0] trail,
  input  rdy_mode_e     mode,
  input  logic          rdy_raw,
  input  logic          rdy_sync,
  output phase_e        phase,
  output logic          phase_done,
  output logic          ack
);
  // Counter preload: a count of n lasts n cycles, a count of 0 is taken as 1.
  function automatic logic [CW-1:0] preload(input logic [CW-1:0] n);
    return (n == '0) ? '0 : n - 1'b1;
  endfunction

  logic [CW-1:0] cnt, act_q, trl_q;
  rdy_mode_e     mode_q;
  logic          last_tick, rdy_ok;

  assign last_tick = (cnt == '0);

  always_comb begin
    unique case (mode_q)
      RDY_SYNC:  rdy_ok = rdy_raw;
      RDY_ASYNC: rdy_ok = rdy_sync;
      default:   rdy_ok = 1'b1;
    endcase
  end

  assign phase_done = last_tick && (phase != PH_IDLE) &&
                      ((phase != PH_ACTIVE) || rdy_ok);
  assign ack = (phase == PH_TRAIL) && last_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      act_q  <= '0;
      trl_q  <= '0;
      mode_q <= RDY_OFF;
    end else begin
      unique case (phase)
        PH_IDLE: if (start) begin
          phase  <= PH_LEAD;
          cnt    <= preload(lead);
          act_q  <= active;
          trl_q  <= trail;
          mode_q <= mode;
        end
        PH_LEAD:
          if (last_tick) begin
            phase <= PH_ACTIVE;
            cnt   <= preload(act_q);
          end else cnt <= cnt - 1'b1;
        PH_ACTIVE:
          if (!last_tick) cnt <= cnt - 1'b1;
          else if (rdy_ok) begin
            phase <= PH_TRAIL;
            cnt   <= preload(trl_q);
          end
        PH_TRAIL:
          if (last_tick) phase <= PH_IDLE;
          else cnt <= cnt - 1'b1;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R2
  lead_to_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_LEAD && cnt == '0) |=> phase == PH_ACTIVE);
  // R3
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ACTIVE && cnt != '0) |=> phase == PH_ACTIVE);
  // R7
  sync_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ACTIVE && cnt == '0 && mode_q == RDY_SYNC && !rdy_raw) |=> phase == PH_ACTIVE);
  // R8
  async_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ACTIVE && cnt == '0 && mode_q == RDY_ASYNC && !rdy_sync) |=> phase == PH_ACTIVE);
  // R6
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> (!ack && phase == PH_IDLE));
endmodule

// File: rtl/ext_write_ctrl.sv
module ext_write_ctrl
  import ewc_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic          req_ack,
  input  logic [CW-1:0] cfg_lead,
  input  logic [CW-1:0] cfg_active,
  input  logic [CW-1:0] cfg_trail,
  input  logic [1:0]    cfg_rdy_mode,
  input  logic          ext_ready,
  output logic          bus_cs_n,
  output logic [AW-1:0] bus_addr,
  output logic          bus_we_n,
  output logic          bus_rnw,
  output logic [DW-1:0] bus_data,
  output logic          bus_data_oe
);
  phase_e        phase;
  logic          phase_done, accept, rdy_synced;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  assign accept = req && (phase == PH_IDLE);

  ewc_rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(ext_ready), .q(rdy_synced)
  );

  ewc_phase_fsm #(.CW(CW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(accept),
    .lead(cfg_lead), .active(cfg_active), .trail(cfg_trail),
    .mode(rdy_mode_e'(cfg_rdy_mode)),
    .rdy_raw(ext_ready), .rdy_sync(rdy_synced),
    .phase(phase), .phase_done(phase_done), .ack(req_ack)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (accept) begin
      addr_q <= req_addr;
      data_q <= req_data;
    end
  end

  assign bus_cs_n    = (phase == PH_IDLE);
  assign bus_rnw     = (phase == PH_IDLE);
  assign bus_we_n    = (phase != PH_ACTIVE);
  assign bus_data_oe = (phase == PH_ACTIVE) || (phase == PH_TRAIL);
  assign bus_addr    = addr_q;
  assign bus_data    = data_q;

  // R5
  strobe_inside_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we_n |-> (!bus_cs_n && !bus_rnw && bus_data_oe));
  // R9
  addr_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cs_n && $past(bus_cs_n)) |-> $stable(bus_addr));
  // R9
  busy_payload_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_cs_n && $past(!bus_cs_n)) |-> ($stable(bus_addr) && $stable(bus_data)));
  // R6
  ack_ends_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |-> (phase_done && !bus_cs_n));
endmodule

// File: tb/ext_write_ctrl_tb.sv
module ext_write_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16, DW = 16, CW = 4;

  logic clk = 0, rst_n = 0, req = 0, ext_ready = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic [CW-1:0] cfg_lead = 1, cfg_active = 1, cfg_trail = 1;
  logic [1:0] cfg_rdy_mode = 0;
  logic req_ack, bus_cs_n, bus_we_n, bus_rnw, bus_data_oe;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_data;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_write_ctrl #(.AW(AW), .DW(DW), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr), .req_data(req_data),
    .req_ack(req_ack), .cfg_lead(cfg_lead), .cfg_active(cfg_active),
    .cfg_trail(cfg_trail), .cfg_rdy_mode(cfg_rdy_mode), .ext_ready(ext_ready),
    .bus_cs_n(bus_cs_n), .bus_addr(bus_addr), .bus_we_n(bus_we_n),
    .bus_rnw(bus_rnw), .bus_data(bus_data), .bus_data_oe(bus_data_oe)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int atleast1(input int n);
    return (n < 1) ? 1 : n;
  endfunction

  // Strobe length from the requirements: decision cycles start at Le+Ae-1.
  function automatic int strobe_len(input int l, input int a, input int mode, input int h);
    int le = atleast1(l), ae = atleast1(a), last;
    last = le + ae - 1;
    if (mode == 1 && h > last) last = h;        // R7
    if (mode == 2 && h + 2 > last) last = h + 2; // R8
    return last - le + 1;
  endfunction

  task automatic access(input int l, input int a, input int t, input int mode, input int h,
                        input logic [AW-1:0] ad, input logic [DW-1:0] dt, input string tag);
    int le = atleast1(l), te = atleast1(t);
    int al = strobe_len(l, a, mode, h);
    int total = le + al + te;
    @(negedge clk);
    req = 1; req_addr = ad; req_data = dt; ext_ready = 0;
    cfg_lead = CW'(l); cfg_active = CW'(a); cfg_trail = CW'(t); cfg_rdy_mode = 2'(mode);
    @(posedge clk);
    for (int k = 0; k < 64; k++) begin
      bit in_lead, in_act, in_trl, busy;
      @(negedge clk);
      ext_ready = (k >= h);
      if (k == 0) begin // R11: disturb the configuration mid-cycle
        cfg_lead = ~CW'(l); cfg_active = ~CW'(a); cfg_trail = ~CW'(t);
        cfg_rdy_mode = (mode == 0) ? 2'd1 : 2'd0;
      end
      in_lead = k < le;
      in_act  = !in_lead && k < le + al;
      in_trl  = !in_lead && !in_act && k < total;
      busy    = k < total;
      chk(bus_cs_n == !busy, tag, bus_cs_n, !busy);
      chk(bus_we_n == !in_act, tag, bus_we_n, !in_act);
      chk(req_ack == (k == total - 1), {tag, " R6"}, req_ack, k == total - 1);
      chk(bus_rnw == !busy && bus_data_oe == (in_act || in_trl), "R5",
          {bus_rnw, bus_data_oe}, {!busy, in_act || in_trl});
      chk(bus_addr == ad && bus_data == dt, "R9", bus_addr, ad);
      if (k == total - 1) req = 0;
      if (!busy) break;
      if (k == 63) chk(0, {tag, " runaway"}, k, total);
    end
    for (int i = 0; i < 2; i++) begin // R9: idle hold while host address moves
      @(negedge clk);
      req_addr = ~ad;
      chk(bus_addr == ad && bus_cs_n, "R9 idle", bus_addr, ad);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(bus_cs_n && bus_we_n && bus_rnw && !bus_data_oe && !req_ack && bus_addr == 0,
        "R1", {bus_cs_n, bus_we_n, bus_rnw, bus_data_oe, req_ack}, 5'b11100);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(bus_cs_n && bus_we_n && bus_rnw && !bus_data_oe && !req_ack && bus_addr == 0,
        "R1", {bus_cs_n, bus_we_n, bus_rnw, bus_data_oe, req_ack}, 5'b11100);

    for (int l = 1; l <= 3; l++)
      for (int a = 1; a <= 3; a++)
        for (int t = 1; t <= 3; t++)
          access(l, a, t, 0, 99, 16'(l * 256 + a * 16 + t), 16'(16'hA500 + l + a + t), "R2 R3 R4");

    access(0, 0, 0, 0, 99, 16'h1234, 16'h0F0F, "R10");
    access(0, 2, 0, 0, 99, 16'h1235, 16'h0F1F, "R10");
    access(2, 0, 1, 1, 0, 16'h1236, 16'h0F2F, "R10");

    for (int l = 1; l <= 3; l++)
      for (int a = 1; a <= 3; a++)
        for (int h = 0; h <= 7; h++)
          access(l, a, 1, 1, h, 16'(16'h2000 + h), 16'(16'h5A00 + l * 16 + a), "R7");

    for (int l = 1; l <= 3; l++)
      for (int a = 1; a <= 3; a++)
        for (int h = 0; h <= 7; h++)
          access(l, a, 2, 2, h, 16'(16'h3000 + h), 16'(16'hC300 + l * 16 + a), "R8");

    access(2, 2, 2, 3, 99, 16'h4444, 16'h7777, "R12");
    access(1, 3, 1, 0, 99, 16'h4445, 16'h7778, "R12");
    access(3, 1, 3, 2, 1, 16'h5555, 16'h9999, "R11");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule